// File: doc/BRIEF.md
# Banked External SRAM Bus Interface

This block joins an 8-bit processor's external memory bus to a 512K x 8 static RAM. The processor puts the low byte of each address on the same eight lines it later uses for data, and it can reach only 64K of external space by itself. The block takes over both jobs that would otherwise need separate parts.

It captures the low address byte from the shared lines while the address strobe is high. It then holds that byte for the rest of the bus cycle while the same lines carry data. The eight high address lines pass straight through to the RAM. Three further address bits come from a small bank register, which the processor loads by writing to one reserved address. From the processor's read and write strobes the block drives the RAM's active-low chip-select, output-enable and write-enable pins.

Software picks a 64K page by writing the bank register. It then uses plain external loads and stores inside that page. The reserved address 0xFFFF belongs to the register in every bank and never reaches the RAM.

Top module: `banked_sram_if`

## Requirements
- R1: While `ale` is high, `sram_addr[7:0]` follows `ad_i`. After `ale` falls, `sram_addr[7:0]` keeps the byte sampled on the last clock with `ale` high, even if `ad_i` changes, until `ale` rises again.
- R2: `sram_addr[15:8]` always equals `addr_hi_i`.
- R3: `sram_addr[18:16]` always equals the bank register. The register changes only on the clock edge that ends a bank-register write.
- R4: A bank-register write is a clock edge with `wr_n` low, `rd_n` high and a 16-bit processor address of 0xFFFF. That address is `{addr_hi_i, low byte}`. The write loads `ad_i[2:0]` into the bank register and ignores `ad_i[7:3]`. During such a write `sram_ce_n`, `sram_oe_n` and `sram_we_n` all stay high.
- R5: `sram_oe_n` is low only when `rd_n` is low, `wr_n` is high and the processor address is not 0xFFFF.
- R6: `sram_we_n` is low only when `wr_n` is low, `rd_n` is high and the processor address is not 0xFFFF. When both strobes are low, neither RAM strobe asserts.
- R7: `sram_ce_n` is low exactly when `sram_oe_n` or `sram_we_n` is low. It is high whenever both processor strobes are high.
- R8: While `rst_n` is low, `sram_ce_n`, `sram_oe_n` and `sram_we_n` are high. The bank register and the latched byte clear to 0.
- R9: Data written at the same 16-bit offsets in each of the eight banks reads back unchanged, so no bank aliases another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset |
| ale | input | 1 | Address strobe; high while the shared lines carry the low address byte |
| ad_i | input | 8 | Shared low-address/data lines from the processor |
| addr_hi_i | input | 8 | Processor high address byte |
| rd_n | input | 1 | Processor read strobe, active low |
| wr_n | input | 1 | Processor write strobe, active low |
| sram_addr | output | 19 | Full RAM address {bank, high byte, latched low byte} |
| sram_ce_n | output | 1 | RAM chip-select, active low |
| sram_oe_n | output | 1 | RAM output-enable, active low |
| sram_we_n | output | 1 | RAM write-enable, active low |

## Verification
Aliasing is the hardest fault to see from the ports. A bank bit that is wrong or stuck still gives clean strobes and believable addresses. It shows only when the same offset in two banks holds different data. The stimulus therefore writes a bank-unique pattern at four shared offsets in all eight banks before it reads any of them back. The bank selects carry junk in their upper data bits. The low-byte hold is exercised by driving unrelated bytes on the shared lines right after the address strobe falls. A cycle reference model checks every clock, and targeted cycles drive both strobes at once and read the reserved address.

// File: rtl/sbi_pkg.sv
package sbi_pkg;
  parameter int DW      = 8;
  parameter int HW      = 8;
  parameter int BW      = 3;
  parameter int CPU_AW  = DW + HW;
  parameter int SAW     = CPU_AW + BW;
  parameter logic [CPU_AW-1:0] BANK_REG_ADDR = {CPU_AW{1'b1}};

  typedef struct packed {
    logic rd;
    logic wr;
  } strobe_t;

  function automatic logic [SAW-1:0] join_addr(input logic [BW-1:0] bank,
                                               input logic [HW-1:0] hi,
                                               input logic [DW-1:0] lo);
    return {bank, hi, lo};
  endfunction

  function automatic logic hits_bank_reg(input logic [HW-1:0] hi,
                                         input logic [DW-1:0] lo);
    return {hi, lo} == BANK_REG_ADDR;
  endfunction
endpackage

// File: rtl/sbi_addr_latch.sv
module sbi_addr_latch #(
  parameter int DW = sbi_pkg::DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] lo_o
);
  logic [DW-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   held_q <= '0;
    else if (ale) held_q <= ad_i;
  end

  assign lo_o = ale ? ad_i : held_q;

  // R1
  lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && !$past(ale)) |-> $stable(lo_o));
endmodule

// File: rtl/sbi_bank_reg.sv
module sbi_bank_reg #(
  parameter int BW = sbi_pkg::BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [BW-1:0] din,
  output logic [BW-1:0] bank_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bank_o <= '0;
    else if (wr_en) bank_o <= din;
  end

  // R3
  bank_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(bank_o));
endmodule

// File: rtl/sbi_strobe_gen.sv
module sbi_strobe_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic reg_hit,
  output logic reg_wr,
  output logic sram_ce_n,
  output logic sram_oe_n,
  output logic sram_we_n
);
  import sbi_pkg::*;

  strobe_t req;
  logic    win;
  logic    rd_go;
  logic    wr_go;

  always_comb begin
    req.rd = !rd_n && rst_n;
    req.wr = !wr_n && rst_n;
    win    = !reg_hit;
    rd_go  = req.rd && !req.wr && win;
    wr_go  = req.wr && !req.rd && win;
    reg_wr = req.wr && !req.rd && reg_hit;
  end

  assign sram_oe_n = !rd_go;
  assign sram_we_n = !wr_go;
  assign sram_ce_n = !(rd_go || wr_go);

  // R5
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> sram_we_n);
  // R7
  ce_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n && wr_n) |-> sram_ce_n);
  // R4
  reg_wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (sram_ce_n && sram_oe_n && sram_we_n));
  // R6
  we_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!wr_n && rd_n));
endmodule

// File: rtl/banked_sram_if.sv
module banked_sram_if #(
  parameter int DW  = sbi_pkg::DW,
  parameter int HW  = sbi_pkg::HW,
  parameter int BW  = sbi_pkg::BW,
  localparam int SAW = DW + HW + BW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ale,
  input  logic [DW-1:0]  ad_i,
  input  logic [HW-1:0]  addr_hi_i,
  input  logic           rd_n,
  input  logic           wr_n,
  output logic [SAW-1:0] sram_addr,
  output logic           sram_ce_n,
  output logic           sram_oe_n,
  output logic           sram_we_n
);
  import sbi_pkg::*;

  logic [DW-1:0] lo_byte;
  logic [BW-1:0] bank;
  logic          reg_hit;
  logic          reg_wr;

  sbi_addr_latch #(.DW(DW)) u_latch (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ad_i(ad_i), .lo_o(lo_byte)
  );

  assign reg_hit = hits_bank_reg(addr_hi_i, lo_byte);

  sbi_strobe_gen u_strobe (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .reg_hit(reg_hit),
    .reg_wr(reg_wr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n)
  );

  sbi_bank_reg #(.BW(BW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .din(ad_i[BW-1:0]), .bank_o(bank)
  );

  assign sram_addr = join_addr(bank, addr_hi_i, lo_byte);

  // R3
  bank_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_wr) |-> (sram_addr[SAW-1:SAW-BW] == $past(ad_i[BW-1:0])));
endmodule

// File: tb/test_banked_sram_if.sv
module test_banked_sram_if;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        ale = 0;
  logic [7:0]  cpu_ad = 0;
  logic [7:0]  hi = 0;
  logic        rd_n = 1;
  logic        wr_n = 1;
  logic [18:0] sram_addr;
  logic        sram_ce_n, sram_oe_n, sram_we_n;

  int checks = 0;
  int failures = 0;
  logic [7:0] mem [int];
  logic [7:0] m_lo = 0;
  logic [2:0] m_bank = 0;

  always #4 clk = ~clk;

  banked_sram_if i_banked_sram_if (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ad_i(cpu_ad), .addr_hi_i(hi),
    .rd_n(rd_n), .wr_n(wr_n), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] eff_lo();
    return ale ? cpu_ad : m_lo;
  endfunction

  function automatic logic is_reserved();
    return {hi, eff_lo()} == 16'hFFFF;
  endfunction

  // reference state and RAM model advance on the rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_lo   <= 0;
      m_bank <= 0;
    end else begin
      if (!wr_n && rd_n && is_reserved()) m_bank <= cpu_ad[2:0];
      if (ale) m_lo <= cpu_ad;
      if (!sram_we_n && !sram_ce_n) mem[int'(sram_addr)] = cpu_ad;
    end
  end

  // cycle compare at the falling edge
  always @(negedge clk) begin
    logic rd, wr, rs, e_oe, e_we;
    rd = !rd_n && rst_n;
    wr = !wr_n && rst_n;
    rs = is_reserved();
    e_oe = !(rd && !wr && !rs);
    e_we = !(wr && !rd && !rs);
    chk("R1/R2/R3 cycle address", {13'd0, sram_addr},
        {13'd0, rst_n ? m_bank : 3'd0, hi, rst_n ? eff_lo() : cpu_ad & {8{ale}}});
    chk("R5/R6/R7 cycle strobes", {29'd0, sram_ce_n, sram_oe_n, sram_we_n},
        {29'd0, e_oe && e_we, e_oe, e_we});
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic addr_phase(input logic [15:0] a);
    step(); ale = 1; cpu_ad = a[7:0]; hi = a[15:8];
    step();
    step(); ale = 0;
    step(); cpu_ad = ~a[7:0] ^ 8'h3C;
    @(negedge clk);
    chk("R1 low byte held after strobe", {24'd0, sram_addr[7:0]}, {24'd0, a[7:0]});
    chk("R2 high byte passthrough", {24'd0, sram_addr[15:8]}, {24'd0, a[15:8]});
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    addr_phase(a);
    step(); cpu_ad = d; wr_n = 0;
    @(negedge clk);
    if (a == 16'hFFFF)
      chk("R4 no strobe on bank write", {29'd0, sram_ce_n, sram_oe_n, sram_we_n}, 32'd7);
    else
      chk("R6 write strobe", {29'd0, sram_ce_n, sram_oe_n, sram_we_n}, 32'd2);
    step();
    step(); wr_n = 1;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
    addr_phase(a);
    step(); rd_n = 0;
    @(negedge clk);
    chk("R5 read strobe", {29'd0, sram_ce_n, sram_oe_n, sram_we_n}, 32'd1);
    d = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 8'h00;
    step(); rd_n = 1;
  endtask

  function automatic logic [7:0] pattern(input int b, input int k);
    return 8'((b * 16 + k) ^ 8'hA5);
  endfunction

  function automatic logic [15:0] offset(input int k);
    return 16'(16'h1020 + k * 16'h1111);
  endfunction

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    chk("R8 strobes high in reset", {29'd0, sram_ce_n, sram_oe_n, sram_we_n}, 32'd7);
    chk("R8 bank zero in reset", {29'd0, sram_addr[18:16]}, 32'd0);
    step(); rst_n = 1;
    step();
    for (int b = 0; b < 8; b++) begin
      bus_wr(16'hFFFF, {5'b10101, 3'(b)});
      @(negedge clk);
      chk("R4 bank loaded from low data bits", {29'd0, sram_addr[18:16]}, b);
      for (int k = 0; k < 4; k++) bus_wr(offset(k), pattern(b, k));
    end
    for (int b = 7; b >= 0; b--) begin
      bus_wr(16'hFFFF, {5'b01010, 3'(b)});
      for (int k = 0; k < 4; k++) begin
        bus_rd(offset(k), d);
        chk($sformatf("R9 bank %0d offset %0d readback", b, k), {24'd0, d}, {24'd0, pattern(b, k)});
      end
    end
    // R3 bank unchanged by ordinary traffic
    bus_wr(16'hFFFE, 8'h07);
    @(negedge clk);
    chk("R3 bank kept after RAM write", {29'd0, sram_addr[18:16]}, 32'd0);
    // R6 both strobes low
    addr_phase(16'h1234);
    step(); rd_n = 0; wr_n = 0;
    @(negedge clk);
    chk("R6 both strobes low gives no RAM strobe", {29'd0, sram_ce_n, sram_oe_n, sram_we_n}, 32'd7);
    step(); rd_n = 1; wr_n = 1;
    // R5 read of reserved address
    addr_phase(16'hFFFF);
    step(); rd_n = 0;
    @(negedge clk);
    chk("R5 reserved read gives no RAM strobe", {29'd0, sram_ce_n, sram_oe_n, sram_we_n}, 32'd7);
    step(); rd_n = 1;
    @(negedge clk);
    chk("R7 idle deselects", {31'd0, sram_ce_n}, 32'd1);
    // R1 transparency while strobe high
    step(); ale = 1; cpu_ad = 8'h5E;
    @(negedge clk);
    chk("R1 transparent while strobe high", {24'd0, sram_addr[7:0]}, 32'h5E);
    step(); ale = 0;
    step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule